// File: doc/BRIEF.md
# Programmable Oversampling Bit Timer

This block produces the per-bit timing strobes used by a UART's serial transmitter and receiver. It runs on a baud-rate tick enable supplied by an upstream divider. The number of ticks that make up one bit period is set by an 8-bit sampling control register and can be any value from 4 to 16. The transmitter receives a bit-boundary strobe every ratio ticks while it is active. The receiver receives a mid-bit sample strobe that is aligned to a falling start edge on the serial line.

The receive side watches the line on every tick. It arms on a high-to-low transition and checks that the line is still low at the first mid-bit sample. A line that has already returned high by then is treated as a glitch, and the timer drops back to idle. An accepted frame yields `FRAME_BITS` sample strobes, the start bit included, and the timer then returns to idle. Each side latches its ratio only while it is idle. A register write made in the middle of a bit stream therefore does not disturb that stream.

Top module: `osr_bit_timer`

## Requirements
- R1: While reset is low and right after reset, `tx_bit_o`, `rx_sample_o` and `rx_busy_o` are 0. Both sides hold a ratio of 16.
- R2: The ratio is decoded from `osr_reg_i[3:0]` only. The values 0, 1, 2 and 3 give 16. The values 4 to 15 give exactly that many ticks per bit, for example 0x0D gives 13. Bits 7:4 have no effect, so 0xF5 gives 5.
- R3: While `tx_active_i` is 1, `tx_bit_o` pulses on every R-th tick counted from the cycle in which `tx_active_i` became 1. While `tx_active_i` is 0, `tx_bit_o` is 0 and the tick count restarts.
- R4: The transmit ratio is the decoded register value in the last cycle in which `tx_active_i` was 0. A register change while `tx_active_i` is 1 does not alter the strobe spacing.
- R5: A start edge is detected on a tick where `rx_i` was 1 on the previous tick and is 0 now, while the receive side is idle. `rx_busy_o` is 1 from the next cycle on.
- R6: The first receive sample strobe fires on the floor(R/2)-th tick after the start-edge tick. Later strobes fire every R ticks after that.
- R7: If `rx_i` is 1 at the first sample tick, no strobe is given and `rx_busy_o` is 0 in the next cycle.
- R8: After `FRAME_BITS` accepted strobes (default 10), the receive side returns to idle. The receive ratio is the decoded register value in the start-edge cycle, and register changes during the frame have no effect.
- R9: Both strobes fire only in cycles where `tick_i` is 1. A transmit strobe and a receive strobe may fire in the same cycle without affecting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Baud-rate tick enable |
| osr_reg_i | input | 8 | Sampling control register |
| tx_active_i | input | 1 | Transmitter is shifting bits |
| rx_i | input | 1 | Synchronised serial receive line |
| tx_bit_o | output | 1 | Transmit bit-boundary strobe |
| rx_sample_o | output | 1 | Receive mid-bit sample strobe |
| rx_busy_o | output | 1 | Receive timer is tracking a frame |

## Verification
The transmit bit strobe and the receive sample strobe are produced by separate counters, and the two can land on the same tick. The bench provokes this by raising `tx_active_i` floor(R/2)-1 ticks before it drives the start edge, with a tick in every cycle, so that both strobes meet on each bit. The bench also writes the register in the same cycle as a start edge, and again in the middle of both streams. A behavioural reference model counts ticks since each side started and judges all three outputs in every cycle. The bench additionally requires that at least one coincident strobe pair was seen.

// File: rtl/osr_pkg.sv
package osr_pkg;
  localparam int unsigned REG_W     = 8;
  localparam int unsigned RATIO_W   = 5;
  localparam int unsigned RATIO_MIN = 4;
  localparam int unsigned RATIO_MAX = 16;

  typedef logic [RATIO_W-1:0] ratio_t;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_HUNT = 2'd1,
    RX_RUN  = 2'd2
  } rx_state_e;

  // low nibble only; codes below the minimum alias to the maximum
  function automatic ratio_t decode_ratio(input logic [REG_W-1:0] reg_v);
    logic [3:0] code;
    code = reg_v[3:0];
    if (code < 4'(RATIO_MIN)) return ratio_t'(RATIO_MAX);
    else                      return ratio_t'(code);
  endfunction
endpackage

// File: rtl/osr_tx_timer.sv
module osr_tx_timer
  import osr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [REG_W-1:0] osr_reg_i,
  input  logic             tx_active_i,
  output logic             tx_bit_o
);
  ratio_t ratio_q;
  ratio_t cnt_q;
  logic   hit;

  assign hit      = tx_active_i && tick_i && (cnt_q == ratio_q - ratio_t'(1));
  assign tx_bit_o = hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ratio_q <= ratio_t'(RATIO_MAX);
      cnt_q   <= '0;
    end else if (!tx_active_i) begin
      ratio_q <= decode_ratio(osr_reg_i);
      cnt_q   <= '0;
    end else if (tick_i) begin
      if (hit) cnt_q <= '0;
      else     cnt_q <= cnt_q + ratio_t'(1);
    end
  end

  a_r2_tx_ratio_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ratio_q >= ratio_t'(RATIO_MIN)) && (ratio_q <= ratio_t'(RATIO_MAX)));

  a_r3_tx_cnt_below_ratio: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < ratio_q);

  a_r4_tx_ratio_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_active_i && $past(tx_active_i)) |-> $stable(ratio_q));
endmodule

// File: rtl/osr_rx_timer.sv
module osr_rx_timer
  import osr_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [REG_W-1:0] osr_reg_i,
  input  logic             rx_i,
  output logic             rx_sample_o,
  output logic             rx_busy_o
);
  localparam int unsigned BIT_W = $clog2(FRAME_BITS + 1);

  rx_state_e        state_q;
  ratio_t           ratio_q;
  ratio_t           cnt_q;
  logic [BIT_W-1:0] bit_q;
  logic             prev_q;
  ratio_t           target;
  logic             busy, hit, edge_det, glitch, sample, last;

  assign busy     = (state_q != RX_IDLE);
  assign target   = (state_q == RX_HUNT) ? (ratio_q >> 1) : ratio_q;
  assign hit      = busy && tick_i && (cnt_q == target - ratio_t'(1));
  assign edge_det = !busy && tick_i && prev_q && !rx_i;
  assign glitch   = hit && (state_q == RX_HUNT) && rx_i;
  assign sample   = hit && !glitch;
  assign last     = sample && (bit_q == BIT_W'(FRAME_BITS - 1));

  assign rx_sample_o = sample;
  assign rx_busy_o   = busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else if (tick_i) prev_q <= rx_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      ratio_q <= ratio_t'(RATIO_MAX);
      cnt_q   <= '0;
      bit_q   <= '0;
    end else if (!busy) begin
      ratio_q <= decode_ratio(osr_reg_i);
      if (edge_det) begin
        state_q <= RX_HUNT;
        cnt_q   <= '0;
        bit_q   <= '0;
      end
    end else if (tick_i) begin
      if (hit) begin
        cnt_q <= '0;
        if (glitch || last) begin
          state_q <= RX_IDLE;
        end else begin
          state_q <= RX_RUN;
          bit_q   <= bit_q + BIT_W'(1);
        end
      end else begin
        cnt_q <= cnt_q + ratio_t'(1);
      end
    end
  end

  a_r2_rx_ratio_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ratio_q >= ratio_t'(RATIO_MIN)) && (ratio_q <= ratio_t'(RATIO_MAX)));

  a_r5_rx_start_from_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(tick_i && !rx_i));

  a_r6_rx_cnt_below_ratio: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> (cnt_q < ratio_q));

  a_r7_rx_glitch_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    glitch |=> !busy);

  a_r8_rx_ratio_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> $stable(ratio_q));

  a_r8_rx_bits_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_q < BIT_W'(FRAME_BITS));
endmodule

// File: rtl/osr_bit_timer.sv
module osr_bit_timer
  import osr_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [REG_W-1:0] osr_reg_i,
  input  logic             tx_active_i,
  input  logic             rx_i,
  output logic             tx_bit_o,
  output logic             rx_sample_o,
  output logic             rx_busy_o
);
  osr_tx_timer u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .osr_reg_i   (osr_reg_i),
    .tx_active_i (tx_active_i),
    .tx_bit_o    (tx_bit_o)
  );

  osr_rx_timer #(.FRAME_BITS(FRAME_BITS)) u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .osr_reg_i   (osr_reg_i),
    .rx_i        (rx_i),
    .rx_sample_o (rx_sample_o),
    .rx_busy_o   (rx_busy_o)
  );

  a_r9_strobes_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_bit_o || rx_sample_o) |-> tick_i);

  a_r3_no_tx_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_active_i |-> !tx_bit_o);
endmodule

// File: tb/osr_bit_timer_bench.sv
`timescale 1ns/1ps
module osr_bit_timer_bench;
  localparam int FRAME_BITS = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_b = 1'b0;
  logic [7:0] reg_b = 8'h00;
  logic       txa_b = 1'b0;
  logic       rx_b = 1'b1;
  logic       tx_bit, rx_samp, rx_busy;

  always #10 clk = ~clk;

  osr_bit_timer #(.FRAME_BITS(FRAME_BITS)) u_osr_bit_timer (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick_b), .osr_reg_i(reg_b),
    .tx_active_i(txa_b), .rx_i(rx_b),
    .tx_bit_o(tx_bit), .rx_sample_o(rx_samp), .rx_busy_o(rx_busy)
  );

  int checks = 0, fails = 0, coinc = 0;
  int tick_div = 1, phase = 0;
  bit done = 0;
  // model state
  int tx_t = 0, tx_r = 16;
  int rx_t = 0, rx_r = 16, m_busy = 0;
  bit m_prev = 1;

  function automatic int dec(input logic [7:0] v);
    int n = int'(v) % 16;
    return (n < 4) ? 16 : n;
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // one clock: drive, compare, advance model
  task automatic cyc(input string tag);
    int e_tx = 0, e_rx = 0, t1, half, idx;
    int end_rx = 0;
    tick_b = (phase == 0);
    phase = (phase + 1) % tick_div;
    #2;
    if (txa_b && tick_b) begin
      t1 = tx_t + 1;
      e_tx = (t1 % tx_r == 0);
    end
    if (m_busy && tick_b) begin
      t1 = rx_t + 1;
      half = rx_r / 2;
      if (t1 >= half && ((t1 - half) % rx_r) == 0) begin
        idx = (t1 - half) / rx_r;
        if (idx == 0 && rx_b) end_rx = 1;
        else begin
          e_rx = 1;
          if (idx == FRAME_BITS - 1) end_rx = 1;
        end
      end
    end
    chk(tag, tx_bit, logic'(e_tx), "tx_bit_o");
    chk(tag, rx_samp, logic'(e_rx), "rx_sample_o");
    chk(tag, rx_busy, logic'(m_busy != 0), "rx_busy_o");
    if (e_tx && e_rx) coinc++;
    @(posedge clk);
    #1;
    if (!txa_b) begin tx_t = 0; tx_r = dec(reg_b); end
    else if (tick_b) tx_t = tx_t + 1;
    if (m_busy) begin
      if (tick_b) rx_t = rx_t + 1;
      if (end_rx) m_busy = 0;
    end else if (tick_b && m_prev && !rx_b) begin
      m_busy = 1; rx_t = 0; rx_r = dec(reg_b);
    end
    if (tick_b) m_prev = rx_b;
    @(negedge clk);
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  task automatic hold(input logic v, input int nticks, input string tag);
    int n = 0;
    rx_b = v;
    while (n < nticks) begin
      if (phase == 0) n++;
      cyc(tag);
    end
  endtask

  task automatic frame(input logic [7:0] d, input int r, input string tag);
    hold(1'b0, r, tag);
    for (int i = 0; i < 8; i++) hold(d[i], r, tag);
    hold(1'b1, r + 2, tag);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", tx_bit, 1'b0, "tx_bit_o in reset");
    chk("R1", rx_samp, 1'b0, "rx_sample_o in reset");
    chk("R1", rx_busy, 1'b0, "rx_busy_o in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", rx_busy, 1'b0, "rx_busy_o after reset");

    // R3 / R1: default ratio 16, tick every cycle
    txa_b = 1; run(70, "R3"); txa_b = 0; run(3, "R3");
    // R2: code aliasing and upper bits ignored, tick every 3rd cycle
    tick_div = 3;
    reg_b = 8'h0D; run(2, "R2"); txa_b = 1; run(120, "R2"); txa_b = 0; run(2, "R2");
    reg_b = 8'h02; run(2, "R2"); txa_b = 1; run(110, "R2"); txa_b = 0; run(2, "R2");
    reg_b = 8'hF5; run(2, "R2"); txa_b = 1; run(60, "R2"); txa_b = 0; run(2, "R2");
    // R4: change while active has no effect
    tick_div = 1;
    reg_b = 8'h06; run(1, "R4"); txa_b = 1; run(15, "R4");
    reg_b = 8'h0F; run(40, "R4"); txa_b = 0; run(2, "R4");

    // R5 R6 R8: full frames at ratios 16, 5, 4
    reg_b = 8'h10; run(3, "R5");
    frame(8'hA5, 16, "R6");
    reg_b = 8'h05; run(3, "R6");
    frame(8'h3C, 5, "R6");
    tick_div = 2;
    reg_b = 8'h04; run(3, "R6");
    frame(8'h81, 4, "R8");
    tick_div = 1;

    // R7: glitch shorter than half a bit
    reg_b = 8'h0C; run(3, "R7");
    hold(1'b0, 3, "R7"); hold(1'b1, 20, "R7");
    hold(1'b0, 5, "R7"); hold(1'b1, 20, "R7");
    chk("R7", rx_busy, 1'b0, "rx_busy_o after glitch");

    // R8: register written in edge cycle and during frame
    reg_b = 8'h09; run(2, "R8");
    rx_b = 1'b0; reg_b = 8'h07; cyc("R8");
    reg_b = 8'h0E; hold(1'b0, 6, "R8");
    for (int i = 0; i < 8; i++) hold(logic'(i % 3 == 0), 7, "R8");
    hold(1'b1, 12, "R8");

    // R9: coincident tx and rx strobes, R = 8
    reg_b = 8'h08; run(3, "R9");
    txa_b = 1; run(3, "R9");
    frame(8'h5A, 8, "R9");
    txa_b = 0; run(4, "R9");
    checks++;
    if (coinc == 0) begin
      fails++;
      $display("FAIL R9 coincident strobes actual %0d expected >0", coinc);
    end
    summary();
  end
endmodule